// File: doc/BRIEF.md
# Sixteen-Pin General Purpose I/O Register Bank

This block is the register file behind a two-port, sixteen-pin general purpose I/O expander. A serial slave front end turns bus traffic into three strobes on a byte-wide host side: a command strobe that loads a register pointer, a data write strobe, and a data read strobe. On the pin side the block takes sixteen raw input levels and drives sixteen output values with sixteen matching output enables.

Each of the two eight-pin ports owns four registers: a live input view, an output latch, a read-back inversion mask and a direction mask. Direction bits decide which pins are driven. Inversion bits change only what the host reads from the input view; they never reach the pins. After every data byte the pointer moves to the other port's register of the same kind. A host can therefore cover both ports in one transfer.

Top module: `pinx_regbank`

## Requirements
- R1: After synchronous reset both output latches hold 0xFF, both inversion masks hold 0x00, both direction masks hold 0xFF and the pointer holds 0. So pin_oe is 0x0000 and pin_out is 0xFFFF.
- R2: A cmd_wr strobe loads host_wdata into the pointer. Pointer values 0/1 select input, 2/3 select output latch, 4/5 select inversion mask and 6/7 select direction mask. An even value selects port 0 (pins 7:0) and an odd value selects port 1 (pins 15:8).
- R3: A host_wr strobe stores host_wdata into the selected writable register. A host_rd strobe places the selected register's value on host_rdata at the next clock edge, and host_rdata then holds until the next accepted read.
- R4: Data writes while the pointer is 0 or 1 are ignored: no latch, mask or pin changes.
- R5: Reading an input register returns each pin level, passed through a two-flop synchronizer, XOR the matching inversion bit. This holds whatever the pin's direction. A level held for three clock edges before the read strobe's edge is seen.
- R6: Reading an output latch returns the stored bits, not the pin levels, even for pins configured as inputs.
- R7: pin_oe[i] is the inverse of direction bit i (1 = input, driver off), and pin_out[i] is output latch bit i.
- R8: After each accepted data read or write with a pointer of 7 or less, pointer bit 0 toggles.
- R9: With a pointer above 7, writes are ignored, reads return 0x00 and the pointer does not move.
- R10: When strobes coincide, cmd_wr wins over host_wr and host_wr wins over host_rd. The losing strobes in that cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Load pointer from host_wdata |
| host_wr | input | 1 | Write host_wdata to selected register |
| host_rd | input | 1 | Read selected register |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Registered read byte |
| pin_in | input | 16 | Raw pin levels |
| pin_out | output | 16 | Output values to the pads |
| pin_oe | output | 16 | Output enables, 1 = drive |

## Verification
A corrupted latch or mask shows on pin_out or pin_oe on the clock edge after the write that caused it, so pin checks follow each write. A wrong pointer shows on host_rdata only at the next read. The bench therefore reads back through both registers of a pair after each sequence, and that exposes a missed or doubled toggle within two reads. Synchronizer faults show as wrong input reads three edges after a pin change.

// File: rtl/pinx_pkg.sv
package pinx_pkg;
    localparam int PORT_W  = 8;
    localparam int N_PORTS = 2;
    localparam int PIN_W   = PORT_W * N_PORTS;
    localparam int CMD_W   = 8;
    localparam int N_REGS  = 8;

    localparam logic [PORT_W-1:0] OUT_RST = '1;
    localparam logic [PORT_W-1:0] POL_RST = '0;
    localparam logic [PORT_W-1:0] CFG_RST = '1;

    typedef enum logic [1:0] {
        KIND_IN  = 2'd0,
        KIND_OUT = 2'd1,
        KIND_POL = 2'd2,
        KIND_CFG = 2'd3
    } reg_kind_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_CMD  = 2'd1,
        OP_WR   = 2'd2,
        OP_RD   = 2'd3
    } host_op_e;

    typedef struct packed {
        logic      valid;
        reg_kind_e kind;
        logic      port;
    } reg_sel_t;

    typedef struct packed {
        logic [PORT_W-1:0] out_bits;
        logic [PORT_W-1:0] pol_bits;
        logic [PORT_W-1:0] cfg_bits;
    } port_regs_t;

    function automatic reg_sel_t decode_sel(input logic [CMD_W-1:0] cmd);
        reg_sel_t s;
        s.valid = (cmd < CMD_W'(N_REGS));
        s.kind  = reg_kind_e'(cmd[2:1]);
        s.port  = cmd[0];
        return s;
    endfunction

    function automatic host_op_e resolve_op(input logic c, input logic w, input logic r);
        if (c)      return OP_CMD;
        else if (w) return OP_WR;
        else if (r) return OP_RD;
        else        return OP_NONE;
    endfunction
endpackage

// File: rtl/pinx_sync.sv
module pinx_sync #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/pinx_cmd_ptr.sv
module pinx_cmd_ptr
    import pinx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  host_op_e         op,
    input  logic [CMD_W-1:0] wdata,
    output logic [CMD_W-1:0] cmd_q,
    output reg_sel_t         sel
);
    logic [CMD_W-1:0] cmd_d;

    assign sel = decode_sel(cmd_q);

    always_comb begin
        cmd_d = cmd_q;
        unique case (op)
            OP_CMD:       cmd_d = wdata;
            OP_WR, OP_RD: if (sel.valid) cmd_d = {cmd_q[CMD_W-1:1], ~cmd_q[0]};
            default:      cmd_d = cmd_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cmd_q <= '0;
        else     cmd_q <= cmd_d;
    end
endmodule

// File: rtl/pinx_port_regs.sv
module pinx_port_regs
    import pinx_pkg::*;
#(
    parameter int PORT_IDX = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  host_op_e          op,
    input  reg_sel_t          sel,
    input  logic [PORT_W-1:0] wdata,
    output port_regs_t        regs
);
    localparam logic MY_PORT = PORT_IDX[0];

    logic hit;
    assign hit = (op == OP_WR) && sel.valid && (sel.port == MY_PORT);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs.out_bits <= OUT_RST;
            regs.pol_bits <= POL_RST;
            regs.cfg_bits <= CFG_RST;
        end else if (hit) begin
            unique case (sel.kind)
                KIND_OUT: regs.out_bits <= wdata;
                KIND_POL: regs.pol_bits <= wdata;
                KIND_CFG: regs.cfg_bits <= wdata;
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/pinx_read_mux.sv
module pinx_read_mux
    import pinx_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  host_op_e                op,
    input  reg_sel_t                sel,
    input  port_regs_t [N_PORTS-1:0] regs_all,
    input  logic [PIN_W-1:0]        pin_sync,
    output logic [PORT_W-1:0]       rdata
);
    port_regs_t        cur;
    logic [PORT_W-1:0] live;
    logic [PORT_W-1:0] byte_d;

    assign cur  = regs_all[sel.port];
    assign live = pin_sync[sel.port*PORT_W +: PORT_W] ^ cur.pol_bits;

    always_comb begin
        byte_d = '0;
        if (sel.valid) begin
            unique case (sel.kind)
                KIND_IN:  byte_d = live;
                KIND_OUT: byte_d = cur.out_bits;
                KIND_POL: byte_d = cur.pol_bits;
                KIND_CFG: byte_d = cur.cfg_bits;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)               rdata <= '0;
        else if (op == OP_RD)  rdata <= byte_d;
    end
endmodule

// File: rtl/pinx_regbank.sv
module pinx_regbank
    import pinx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [CMD_W-1:0]  host_wdata,
    output logic [PORT_W-1:0] host_rdata,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pin_out,
    output logic [PIN_W-1:0]  pin_oe
);
    host_op_e                 op;
    reg_sel_t                 sel;
    logic [CMD_W-1:0]         cur_cmd;
    logic [PIN_W-1:0]         pin_sync;
    port_regs_t [N_PORTS-1:0] regs_all;

    assign op = resolve_op(cmd_wr, host_wr, host_rd);

    pinx_sync #(.W(PIN_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pin_sync)
    );

    pinx_cmd_ptr u_ptr (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .wdata (host_wdata),
        .cmd_q (cur_cmd),
        .sel   (sel)
    );

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        pinx_port_regs #(.PORT_IDX(p)) u_regs (
            .clk   (clk),
            .rst   (rst),
            .op    (op),
            .sel   (sel),
            .wdata (host_wdata[PORT_W-1:0]),
            .regs  (regs_all[p])
        );
        assign pin_out[p*PORT_W +: PORT_W] = regs_all[p].out_bits;
        assign pin_oe[p*PORT_W +: PORT_W]  = ~regs_all[p].cfg_bits;
    end

    pinx_read_mux u_rmux (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .sel      (sel),
        .regs_all (regs_all),
        .pin_sync (pin_sync),
        .rdata    (host_rdata)
    );
endmodule

// File: rtl/pinx_regbank_chk.sv
module pinx_regbank_chk (
    input logic        clk,
    input logic        rst,
    input logic        cmd_wr,
    input logic        host_wr,
    input logic        host_rd,
    input logic [7:0]  host_wdata,
    input logic [7:0]  host_rdata,
    input logic [15:0] pin_out,
    input logic [15:0] pin_oe,
    input logic [7:0]  cur_cmd
);
    logic rd_only;
    logic wr_only;
    assign rd_only = host_rd && !cmd_wr && !host_wr;
    assign wr_only = host_wr && !cmd_wr;

    a_r1_reset_pins: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_oe == 16'h0000 && pin_out == 16'hFFFF && cur_cmd == 8'd0));

    a_r2_cmd_load: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> cur_cmd == $past(host_wdata));

    a_r3_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        !rd_only |=> $stable(host_rdata));

    a_r4_input_write_ignored: assert property (@(posedge clk) disable iff (rst)
        (wr_only && cur_cmd < 8'd2) |=> ($stable(pin_out) && $stable(pin_oe)));

    a_r8_ptr_toggle: assert property (@(posedge clk) disable iff (rst)
        ((rd_only || wr_only) && cur_cmd <= 8'd7) |=>
            cur_cmd == {$past(cur_cmd[7:1]), ~$past(cur_cmd[0])});

    a_r9_invalid_read_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_only && cur_cmd > 8'd7) |=> host_rdata == 8'h00);

    a_r9_invalid_ptr_still: assert property (@(posedge clk) disable iff (rst)
        ((rd_only || wr_only) && cur_cmd > 8'd7) |=> $stable(cur_cmd));

    a_r10_cmd_wins: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && host_wr) |=> ($stable(pin_out) && $stable(pin_oe)));
endmodule

bind pinx_regbank pinx_regbank_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_wr     (cmd_wr),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .pin_out    (pin_out),
    .pin_oe     (pin_oe),
    .cur_cmd    (cur_cmd)
);

// File: tb/pinx_regbank_test.sv
module pinx_regbank_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_wr = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_wdata = 8'h00;
    logic [7:0]  host_rdata;
    logic [15:0] pin_in = 16'h0000;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pinx_regbank uut (
        .clk        (clk),
        .rst        (rst),
        .cmd_wr     (cmd_wr),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .pin_in     (pin_in),
        .pin_out    (pin_out),
        .pin_oe     (pin_oe)
    );

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic strobe(input logic c, input logic w, input logic r, input logic [7:0] d);
        @(negedge clk);
        cmd_wr = c; host_wr = w; host_rd = r; host_wdata = d;
        @(negedge clk);
        cmd_wr = 0; host_wr = 0; host_rd = 0;
    endtask

    task automatic do_cmd(input logic [7:0] d);  strobe(1, 0, 0, d); endtask
    task automatic do_wr(input logic [7:0] d);   strobe(0, 1, 0, d); endtask
    task automatic do_rd(output logic [7:0] d);
        strobe(0, 0, 1, 8'h00);
        d = host_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 pin_oe", pin_oe, 16'h0000);
        check("R1 pin_out", pin_out, 16'hFFFF);
        check("R3 rdata reset", {8'h00, host_rdata}, 16'h0000);
        do_rd(v); check("R1 ptr=0 reads input p0", {8'h00, v}, 16'h0000);
        do_cmd(8'd4); do_rd(v); check("R1 pol0", {8'h00, v}, 16'h0000);
        do_rd(v); check("R1 pol1 after R8 toggle", {8'h00, v}, 16'h0000);
        do_cmd(8'd6); do_rd(v); check("R1 cfg0", {8'h00, v}, 16'h00FF);
        do_cmd(8'd3); do_rd(v); check("R1 out1", {8'h00, v}, 16'h00FF);
    endtask

    task automatic t_dir_out();
        do_cmd(8'd6); do_wr(8'h0F); do_wr(8'hF0);
        check("R7 R8 pin_oe from cfg", pin_oe, ~16'hF00F);
        do_cmd(8'd2); do_wr(8'hA5); do_wr(8'h3C);
        check("R2 R3 R7 pin_out", pin_out, 16'h3CA5);
    endtask

    task automatic t_input_read();
        logic [7:0] v;
        pin_in = 16'h1234;
        repeat (3) @(negedge clk);
        do_cmd(8'd0); do_rd(v); check("R5 in0 mixed dirs", {8'h00, v}, 16'h0034);
        do_rd(v); check("R5 R8 in1", {8'h00, v}, 16'h0012);
        pin_in = 16'hBEEF;
        repeat (3) @(negedge clk);
        do_cmd(8'd1); do_rd(v); check("R5 in1 new level", {8'h00, v}, 16'h00BE);
        do_rd(v); check("R8 wrap to in0", {8'h00, v}, 16'h00EF);
        pin_in = 16'h1234;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_polarity();
        logic [7:0] v;
        do_cmd(8'd4); do_wr(8'hFF); do_wr(8'h0F);
        check("R5 pol no pin effect", pin_out, 16'h3CA5);
        do_cmd(8'd0); do_rd(v); check("R5 inverted in0", {8'h00, v}, 16'h00CB);
        do_rd(v); check("R5 inverted in1", {8'h00, v}, 16'h001D);
    endtask

    task automatic t_input_write_ignored();
        logic [7:0] v;
        do_cmd(8'd0); do_wr(8'h55); do_wr(8'hAA);
        check("R4 pin_out", pin_out, 16'h3CA5);
        check("R4 pin_oe", pin_oe, 16'h0FF0);
        do_cmd(8'd0); do_rd(v); check("R4 in0 unchanged", {8'h00, v}, 16'h00CB);
        do_cmd(8'd4); do_rd(v); check("R4 pol0 unchanged", {8'h00, v}, 16'h00FF);
        do_rd(v); check("R4 pol1 unchanged", {8'h00, v}, 16'h000F);
    endtask

    task automatic t_output_readback();
        logic [7:0] v;
        do_cmd(8'd6); do_wr(8'hFF); do_wr(8'hFF);
        check("R7 all inputs", pin_oe, 16'h0000);
        do_cmd(8'd2); do_wr(8'h66);
        pin_in = 16'h0000;
        repeat (3) @(negedge clk);
        do_cmd(8'd2); do_rd(v); check("R6 out0 latch not pins", {8'h00, v}, 16'h0066);
        do_rd(v); check("R6 out1 latch", {8'h00, v}, 16'h003C);
        check("R7 pin_out keeps latch", pin_out, 16'h3C66);
    endtask

    task automatic t_invalid();
        logic [7:0] v;
        do_cmd(8'd9); do_wr(8'h00);
        check("R9 write ignored out", pin_out, 16'h3C66);
        check("R9 write ignored oe", pin_oe, 16'h0000);
        do_rd(v); check("R9 read zero", {8'h00, v}, 16'h0000);
        do_cmd(8'hFF); do_rd(v); check("R9 read zero ff", {8'h00, v}, 16'h0000);
    endtask

    task automatic t_priority();
        logic [7:0] v;
        do_cmd(8'd2); do_wr(8'h11); do_wr(8'h22);
        check("R3 setup", pin_out, 16'h2211);
        strobe(1, 1, 0, 8'h02);
        check("R10 cmd beats wr", pin_out, 16'h2211);
        strobe(0, 1, 1, 8'h77);
        check("R10 wr applied", pin_out, 16'h2277);
        check("R10 rd dropped", {8'h00, host_rdata}, 16'h0000);
        do_rd(v); check("R10 single toggle", {8'h00, v}, 16'h0022);
    endtask

    task automatic report();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_dir_out();
        t_input_read();
        t_polarity();
        t_input_write_ignored();
        t_output_readback();
        t_invalid();
        t_priority();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end
endmodule